// File: doc/BRIEF.md
# Encoded Priority Interrupt Controller

This block collects interrupt requests from three external active-low pins and from a parameterised set of internal peripheral request lines. It presents to the processor a single interrupt level from 0 (none) to 7. When the processor acknowledges a level, the block answers with an 8-bit vector number.

The external pins work in one of two modes. In fixed mode each pin is its own source, and each has a hard-wired level. In encoded mode the three pins together carry one 3-bit level code from one source. Every source also has a 2-bit priority that orders sources which share the same level. Each peripheral has its own configuration: a level, a priority, and a choice between an automatic vector and a programmed vector. Any source can be masked.

The processor supplies its current mask level. Level 7 always gets through that mask.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after release with no requests, `irq_level_o` is 0, `vector_valid_o` is 0 and `pending_o` is all zero.
- R2: In fixed mode (`encoded_mode_i`=0), pin k is active when low. Pin 0, pin 1 and pin 2 request levels 1, 4 and 7 respectively. Their status appears on `pending_o[2:0]`.
- R3: In encoded mode, the active-low pins give a level L, where bit k of L is the inverse of pin k. L=0 means no request. The request belongs to source 0, and `pending_o[2:1]` stays 0.
- R4: In encoded mode, a level code is adopted only after two consecutive synchronised samples agree. A code held for a single clock is never presented. A code held for two clocks is presented.
- R5: Among eligible sources, the one presented has the highest level. A tie on level goes to the higher priority value. A tie on both goes to the lowest source index. Peripheral p is source index 3+p.
- R6: A set bit in `src_mask_i` removes that source from presentation and from acknowledge. Its bit in `pending_o` still reflects the request.
- R7: The winning level L is presented only when L > `cpu_mask_i` or L = 7. Otherwise `irq_level_o` is 0.
- R8: An acknowledge that resolves to an external source, or to a peripheral whose `per_autovec_i` bit is set, returns vector 24+L.
- R9: An acknowledge that resolves to a peripheral whose autovector bit is clear returns the byte at `per_vector_i[8p+7:8p]`.
- R10: An acknowledge at a level with no eligible source returns the spurious vector 24.
- R11: `vector_valid_o` is high in exactly the cycle after each clock in which `iack_i` is sampled high.
- R12: A peripheral configured with level 0 is never pending and never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_ni | input | 3 | External request pins, active low |
| encoded_mode_i | input | 1 | 1: pins carry a 3-bit level code; 0: fixed levels 1/4/7 |
| ext_prio_i | input | 6 | Priority of external source k at bits [2k+1:2k] |
| per_req_i | input | N_PER | Peripheral request lines, active high |
| per_level_i | input | 3*N_PER | Level of peripheral p at [3p+2:3p] |
| per_prio_i | input | 2*N_PER | Priority of peripheral p at [2p+1:2p] |
| per_autovec_i | input | N_PER | 1: peripheral p answers with autovector |
| per_vector_i | input | 8*N_PER | Programmed vector of peripheral p |
| src_mask_i | input | N_PER+3 | Per-source mask, 1 = masked |
| cpu_mask_i | input | 3 | Processor mask level |
| iack_i | input | 1 | Acknowledge strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| irq_level_o | output | 3 | Presented interrupt level |
| vector_valid_o | output | 1 | Vector response valid |
| vector_o | output | 8 | Vector number |
| pending_o | output | N_PER+3 | Per-source pending status |

## Verification
The bench builds the block with N_PER=4, which gives seven sources. With that size every pin pattern in both modes can be swept, along with every pairing of encoded level and processor mask. All sixteen combinations of peripheral requests are also swept. The four peripherals are configured with two of them tied on level and priority and one at a higher level, so the index tie-break and the level-over-priority ordering are both exercised. Each acknowledge's expected vector is derived from the same arithmetic rule that picks the expected winner.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W  = 3;
  localparam int PRIO_W = 2;
  localparam int VEC_W  = 8;
  localparam int EXT_N  = 3;
  localparam int KEY_W  = LVL_W + PRIO_W;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  localparam lvl_t LVL_NMI = lvl_t'(7);

  function automatic lvl_t fixed_pin_lvl(input int unsigned pin);
    case (pin)
      0:       return lvl_t'(1);
      1:       return lvl_t'(4);
      default: return lvl_t'(7);
    endcase
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync import irq_pkg::*; #(
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXT_N-1:0] pins_ni,
  output logic [EXT_N-1:0] act_o,
  output lvl_t             code_o
);
  logic [STAGES-1:0][EXT_N-1:0] sync_q;
  logic [EXT_N-1:0] s_last, prev_q;
  lvl_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= ~pins_ni;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign s_last = sync_q[STAGES-1];

  // code accepted only once two consecutive samples agree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      acc_q  <= '0;
    end else begin
      prev_q <= s_last;
      if (s_last == prev_q) acc_q <= lvl_t'(s_last);
    end
  end

  assign act_o  = s_last;
  assign code_o = acc_q;

  AST_FILTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_q) |-> ($past(s_last, 1) == $past(s_last, 2))); // R4
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map import irq_pkg::*; #(
  parameter int N_PER = 8
) (
  input  logic                             encoded_i,
  input  logic [EXT_N-1:0]                 ext_act_i,
  input  lvl_t                             ext_code_i,
  input  logic [EXT_N*PRIO_W-1:0]          ext_prio_i,
  input  logic [N_PER-1:0]                 per_req_i,
  input  logic [N_PER*LVL_W-1:0]           per_level_i,
  input  logic [N_PER*PRIO_W-1:0]          per_prio_i,
  input  logic [N_PER+EXT_N-1:0]           src_mask_i,
  output logic [(N_PER+EXT_N)*LVL_W-1:0]   src_lvl_o,
  output logic [(N_PER+EXT_N)*PRIO_W-1:0]  src_prio_o,
  output logic [N_PER+EXT_N-1:0]           pend_o,
  output logic [N_PER+EXT_N-1:0]           elig_o
);
  for (genvar e = 0; e < EXT_N; e++) begin : g_ext
    if (e == 0) begin : g_enc_src
      always_comb begin
        if (encoded_i) begin
          pend_o[e]                   = (ext_code_i != '0);
          src_lvl_o[e*LVL_W +: LVL_W] = ext_code_i;
        end else begin
          pend_o[e]                   = ext_act_i[e];
          src_lvl_o[e*LVL_W +: LVL_W] = fixed_pin_lvl(e);
        end
      end
    end else begin : g_fix_src
      always_comb begin
        pend_o[e]                   = ext_act_i[e] && !encoded_i;
        src_lvl_o[e*LVL_W +: LVL_W] = fixed_pin_lvl(e);
      end
    end
    assign src_prio_o[e*PRIO_W +: PRIO_W] = ext_prio_i[e*PRIO_W +: PRIO_W];
  end

  for (genvar p = 0; p < N_PER; p++) begin : g_per
    localparam int S = p + EXT_N;
    assign src_lvl_o[S*LVL_W +: LVL_W]    = per_level_i[p*LVL_W +: LVL_W];
    assign src_prio_o[S*PRIO_W +: PRIO_W] = per_prio_i[p*PRIO_W +: PRIO_W];
    assign pend_o[S] = per_req_i[p] && (per_level_i[p*LVL_W +: LVL_W] != '0);
  end

  assign elig_o = pend_o & ~src_mask_i;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        en_i,
  input  logic [N*LVL_W-1:0]  lvl_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o,
  output lvl_t                lvl_o
);
  logic [KEY_W-1:0] best_key;

  // strict compare: lowest index keeps a full tie
  always_comb begin
    best_key = '0;
    valid_o  = 1'b0;
    idx_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i[i] && ({lvl_i[i*LVL_W +: LVL_W], prio_i[i*PRIO_W +: PRIO_W]} > best_key)) begin
        best_key = {lvl_i[i*LVL_W +: LVL_W], prio_i[i*PRIO_W +: PRIO_W]};
        valid_o  = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
    lvl_o = best_key[KEY_W-1:PRIO_W];
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irq_pkg::*; #(
  parameter int N_PER        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int AUTOVEC_BASE = 24,
  parameter int SPUR_VEC     = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [EXT_N-1:0]            ext_irq_ni,
  input  logic                        encoded_mode_i,
  input  logic [EXT_N*PRIO_W-1:0]     ext_prio_i,
  input  logic [N_PER-1:0]            per_req_i,
  input  logic [N_PER*LVL_W-1:0]      per_level_i,
  input  logic [N_PER*PRIO_W-1:0]     per_prio_i,
  input  logic [N_PER-1:0]            per_autovec_i,
  input  logic [N_PER*VEC_W-1:0]      per_vector_i,
  input  logic [N_PER+EXT_N-1:0]      src_mask_i,
  input  logic [LVL_W-1:0]            cpu_mask_i,
  input  logic                        iack_i,
  input  logic [LVL_W-1:0]            iack_level_i,
  output logic [LVL_W-1:0]            irq_level_o,
  output logic                        vector_valid_o,
  output logic [VEC_W-1:0]            vector_o,
  output logic [N_PER+EXT_N-1:0]      pending_o
);
  localparam int N_SRC = N_PER + EXT_N;
  localparam int IDX_W = $clog2(N_SRC);

  logic [EXT_N-1:0]         ext_act;
  lvl_t                     ext_code;
  logic [N_SRC*LVL_W-1:0]   src_lvl;
  logic [N_SRC*PRIO_W-1:0]  src_prio;
  logic [N_SRC-1:0]         pend, elig, ack_en, src_auto;
  logic [N_SRC*VEC_W-1:0]   src_pvec;
  logic                     pres_valid, ack_valid;
  logic [IDX_W-1:0]         pres_idx, ack_idx;
  lvl_t                     pres_lvl, ack_lvl;
  vec_t                     ack_vec;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_ni(ext_irq_ni),
    .act_o  (ext_act),
    .code_o (ext_code)
  );

  irq_src_map #(.N_PER(N_PER)) u_map (
    .encoded_i  (encoded_mode_i),
    .ext_act_i  (ext_act),
    .ext_code_i (ext_code),
    .ext_prio_i (ext_prio_i),
    .per_req_i  (per_req_i),
    .per_level_i(per_level_i),
    .per_prio_i (per_prio_i),
    .src_mask_i (src_mask_i),
    .src_lvl_o  (src_lvl),
    .src_prio_o (src_prio),
    .pend_o     (pend),
    .elig_o     (elig)
  );

  irq_arbiter #(.N(N_SRC), .IDX_W(IDX_W)) u_arb_pres (
    .en_i   (elig),
    .lvl_i  (src_lvl),
    .prio_i (src_prio),
    .valid_o(pres_valid),
    .idx_o  (pres_idx),
    .lvl_o  (pres_lvl)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign ack_en[i] = elig[i] && (src_lvl[i*LVL_W +: LVL_W] == iack_level_i);
    if (i < EXT_N) begin : g_ext_vec
      assign src_auto[i]                = 1'b1;
      assign src_pvec[i*VEC_W +: VEC_W] = '0;
    end else begin : g_per_vec
      assign src_auto[i]                = per_autovec_i[i-EXT_N];
      assign src_pvec[i*VEC_W +: VEC_W] = per_vector_i[(i-EXT_N)*VEC_W +: VEC_W];
    end
  end

  irq_arbiter #(.N(N_SRC), .IDX_W(IDX_W)) u_arb_ack (
    .en_i   (ack_en),
    .lvl_i  (src_lvl),
    .prio_i (src_prio),
    .valid_o(ack_valid),
    .idx_o  (ack_idx),
    .lvl_o  (ack_lvl)
  );

  always_comb begin
    if (!ack_valid)             ack_vec = vec_t'(SPUR_VEC);
    else if (src_auto[ack_idx]) ack_vec = vec_t'(AUTOVEC_BASE) + vec_t'(ack_lvl);
    else                        ack_vec = src_pvec[ack_idx*VEC_W +: VEC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_level_o    <= '0;
      vector_valid_o <= 1'b0;
      vector_o       <= '0;
    end else begin
      irq_level_o    <= (pres_valid && (pres_lvl == LVL_NMI || pres_lvl > cpu_mask_i)) ? pres_lvl : '0;
      vector_valid_o <= iack_i;
      if (iack_i) vector_o <= ack_vec;
    end
  end

  assign pending_o = pend;

  AST_ACK_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i |=> vector_valid_o); // R11
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |=> !vector_valid_o); // R11
  AST_MASK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0 && irq_level_o != LVL_NMI) |-> (irq_level_o > $past(cpu_mask_i))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o == '0) |=> (irq_level_o == '0)); // R5
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int NP = 4;
  localparam int NS = NP + 3;

  logic clk = 0, rst_n = 0;
  logic [2:0] ext_irq_n = 3'b111;
  logic enc = 0;
  logic [5:0] ext_prio = 6'b10_01_00;
  logic [NP-1:0] per_req = '0;
  logic [NP*3-1:0] per_level = {3'd3, 3'd5, 3'd3, 3'd3};
  logic [NP*2-1:0] per_prio = {2'd2, 2'd0, 2'd2, 2'd1};
  logic [NP-1:0] per_auto = '0;
  logic [NP*8-1:0] per_vec = {8'h43, 8'h42, 8'h41, 8'h40};
  logic [NS-1:0] smask = '0;
  logic [2:0] cmask = 0;
  logic iack = 0;
  logic [2:0] iack_lvl = 0;
  logic [2:0] irq_level;
  logic vvalid;
  logic [7:0] vec;
  logic [NS-1:0] pend;

  int n_tests = 0, n_fail = 0;

  always #5ns clk = ~clk;

  irq_prio_ctrl #(.N_PER(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_ni(ext_irq_n), .encoded_mode_i(enc),
    .ext_prio_i(ext_prio), .per_req_i(per_req), .per_level_i(per_level),
    .per_prio_i(per_prio), .per_autovec_i(per_auto), .per_vector_i(per_vec),
    .src_mask_i(smask), .cpu_mask_i(cmask), .iack_i(iack), .iack_level_i(iack_lvl),
    .irq_level_o(irq_level), .vector_valid_o(vvalid), .vector_o(vec), .pending_o(pend)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle acknowledge; checks vector and the pulse shape
  task automatic ack(input int lvl, input int exp_vec, input string req);
    @(negedge clk);
    iack = 1; iack_lvl = 3'(lvl);
    @(negedge clk);
    iack = 0;
    chk({req, " vector"}, vec, exp_vec);
    chk("R11 valid high", vvalid, 1);
    @(negedge clk);
    chk("R11 valid drops", vvalid, 0);
  endtask

  int lv[NP] = '{3, 3, 5, 3};
  int pr[NP] = '{1, 2, 0, 2};

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    settle(2);
    chk("R1 reset level", irq_level, 0);
    chk("R1 reset valid", vvalid, 0);
    rst_n = 1;
    settle(6);
    chk("R1 idle level", irq_level, 0);
    chk("R1 idle pending", int'(pend), 0);

    // R2 fixed mode sweep
    for (int p = 0; p < 8; p++) begin
      ext_irq_n = ~3'(p);
      settle(6);
      chk("R2 fixed level", irq_level, p[2] ? 7 : p[1] ? 4 : p[0] ? 1 : 0);
      chk("R2 pending", int'(pend[2:0]), p);
    end
    ext_irq_n = 3'b101;
    settle(6);
    ack(4, 28, "R8 fixed autovector");
    ext_irq_n = 3'b111;

    // R3 / R7 encoded level versus processor mask
    enc = 1;
    for (int l = 0; l < 8; l++) begin
      for (int m = 0; m < 8; m++) begin
        ext_irq_n = ~3'(l); cmask = 3'(m);
        settle(8);
        chk("R3 R7 encoded level", irq_level, (l != 0 && (l == 7 || l > m)) ? l : 0);
      end
      chk("R3 pending", int'(pend[2:0]), l != 0 ? 1 : 0);
    end
    cmask = 0;

    // R4 glitch filter
    ext_irq_n = ~3'd3;
    settle(8);
    begin
      int seen;
      seen = 0;
      ext_irq_n = ~3'd6;
      @(negedge clk);
      ext_irq_n = ~3'd3;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (irq_level == 6) seen++;
      end
      chk("R4 single-cycle code ignored", seen, 0);
      chk("R4 level kept", irq_level, 3);
      seen = 0;
      ext_irq_n = ~3'd5;
      @(negedge clk); @(negedge clk);
      ext_irq_n = ~3'd3;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (irq_level == 5) seen++;
      end
      chk("R4 two-cycle code taken", int'(seen > 0), 1);
    end
    ext_irq_n = 3'b111;
    settle(8);

    // R5 / R9 / R10 peripheral sweep
    for (int r = 0; r < 16; r++) begin
      int best, bkey;
      best = -1; bkey = 0;
      for (int p = 0; p < NP; p++)
        if (r[p] && (lv[p] * 4 + pr[p]) > bkey) begin best = p; bkey = lv[p] * 4 + pr[p]; end
      per_req = 4'(r);
      settle(3);
      chk("R5 winner level", irq_level, best < 0 ? 0 : lv[best]);
      if (best < 0) ack(3, 24, "R10 spurious");
      else          ack(lv[best], 8'h40 + best, "R5 R9 programmed");
    end

    // R6 mask
    per_req = 4'b0101;
    smask = 7'b0100000;
    settle(3);
    chk("R6 masked excluded", irq_level, 3);
    chk("R6 pending kept", int'(pend[5]), 1);
    ack(5, 24, "R6 R10 masked ack");
    smask = '0;

    // R8 peripheral autovector
    per_auto = 4'b0010;
    per_req = 4'b0010;
    settle(3);
    ack(3, 27, "R8 peripheral autovector");
    per_auto = '0;

    // R10 empty level
    ack(6, 24, "R10 empty level");

    // R12 level-0 peripheral
    per_level[2:0] = 3'd0;
    per_req = 4'b0001;
    settle(3);
    chk("R12 pending", int'(pend[3]), 0);
    chk("R12 level", irq_level, 0);
    per_req = '0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule